// File: doc/BRIEF.md
# Load-Balanced Mesh Route Computation

This block is the route-computation stage of one router in a two-dimensional mesh network that has no flit buffers and resolves contention by deflection. Every cycle it looks at the header of the flit on each of the five input ports (local, east, west, north, south). It compares the router's own coordinates with the flit's destination and names the output port the flit wants. Arbitration between flits that want the same port, deflection and the crossbar are handled downstream. This block only produces the wish and the header bit to forward.

To spread load over both dimensions, the router keeps a one-bit order state. A flit that starts its journey here (it arrives on the local port and its source coordinates equal the router's coordinates) takes the current order state as its routing order, and the state then flips. The chosen order leaves the block in the flit header. Every later router routes that flit X-first or Y-first according to the header bit, even after a deflection. A flit that has reached its destination is sent to the local output for ejection.

The order state is a two-state machine. State `ST_XFIRST` (0) goes to `ST_YFIRST` (1) on an injection. State `ST_YFIRST` goes back to `ST_XFIRST` on an injection. Both states hold when no injection happens. Reset enters `ST_XFIRST`. Directions are coded 0 local, 1 east, 2 west, 3 north, 4 south. Port index k in the flattened buses uses the same order: 0 local, 1 east, 2 west, 3 north, 4 south.

Top module: `rc_lb_route`

## Requirements
- R1: After reset the order state is X-first, so the first injected flit gets order bit 0.
- R2: The order state flips on every cycle with an injection, and holds otherwise. An injection is `loc_vld`=1 with source coordinates equal to `here_x`/`here_y`. A local flit with other source coordinates, or `loc_vld`=0, leaves the state unchanged.
- R3: For an injected flit, `out_ord[0]` equals the order state before the flip, and its direction is computed with that order.
- R4: On any port, a flit whose destination equals (`here_x`,`here_y`) gets direction 0 (local).
- R5: The X move is east (1) when the current X is below the destination X, and west (2) when it is above. The Y move is north (3) when the current Y is below the destination Y, and south (4) when it is above.
- R6: With order bit 0 (X-first), a flit moves in X while the X coordinates differ, and in Y once they match.
- R7: With order bit 1 (Y-first), a flit moves in Y while the Y coordinates differ, and in X once they match.
- R8: At injection, if the offset in the chosen first dimension is already zero, the flit moves in the other dimension. Its order bit is still the chosen one, and the state still flips.
- R9: Network-port flits, and local flits that are not injections, are routed by their incoming order bit, and that bit is forwarded unchanged on `out_ord`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| here_x | input | XW | X coordinate of this router |
| here_y | input | YW | Y coordinate of this router |
| loc_vld | input | 1 | Local input holds a flit |
| loc_src_x | input | XW | Source X of the local flit |
| loc_src_y | input | YW | Source Y of the local flit |
| in_dst_x | input | 5*XW | Destination X per input port |
| in_dst_y | input | 5*YW | Destination Y per input port |
| in_ord | input | 5 | Incoming order bit per port (0 X-first, 1 Y-first) |
| out_dir | output | 15 | Desired output direction per port, 3 bits each |
| out_ord | output | 5 | Order bit to forward in each flit header |

## Verification
The bench goes after the order state. A machine that flipped on non-injections (an invalid local slot, or a local flit from elsewhere) would hand out the wrong order bits from then on. One that did not flip would send every injected flit the same way. It also targets flits already aligned in one or both dimensions. A wrong ejection compare would send an arrived flit back into the mesh. Ignoring a zero offset in the first dimension would stall the flit on a non-move or send it the wrong way. Random traffic over random router positions catches swapped east/west or north/south codes, and transit flits whose order bit is overridden by the local state.

// File: rtl/rc_pkg.sv
package rc_pkg;

    localparam int NUM_PORTS  = 5;
    localparam int PORT_LOCAL = 0;
    localparam int DIR_W      = 3;

    typedef enum logic [DIR_W-1:0] {
        DIR_LOCAL = 3'd0,
        DIR_EAST  = 3'd1,
        DIR_WEST  = 3'd2,
        DIR_NORTH = 3'd3,
        DIR_SOUTH = 3'd4
    } dir_e;

    typedef enum logic {
        ST_XFIRST = 1'b0,
        ST_YFIRST = 1'b1
    } ord_st_e;

endpackage

// File: rtl/rc_order_fsm.sv
module rc_order_fsm
    import rc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    inject,
    output ord_st_e cur_state
);

    ord_st_e state_q;
    ord_st_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_XFIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_XFIRST: if (inject) state_d = ST_YFIRST;
            ST_YFIRST: if (inject) state_d = ST_XFIRST;
            default:   state_d = ST_XFIRST;
        endcase
    end

    assign cur_state = state_q;

endmodule

// File: rtl/rc_dir_calc.sv
module rc_dir_calc
    import rc_pkg::*;
#(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    input  logic          y_first,
    output dir_e          dir
);

    logic x_off, y_off;
    dir_e x_move, y_move;

    always_comb begin
        x_off  = (cur_x != dst_x);
        y_off  = (cur_y != dst_y);
        x_move = (cur_x < dst_x) ? DIR_EAST  : DIR_WEST;
        y_move = (cur_y < dst_y) ? DIR_NORTH : DIR_SOUTH;
        if (!x_off && !y_off)  dir = DIR_LOCAL;
        else if (!y_first)     dir = x_off ? x_move : y_move;
        else                   dir = y_off ? y_move : x_move;
    end

endmodule

// File: rtl/rc_lb_route.sv
module rc_lb_route
    import rc_pkg::*;
#(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [XW-1:0]              here_x,
    input  logic [YW-1:0]              here_y,
    input  logic                       loc_vld,
    input  logic [XW-1:0]              loc_src_x,
    input  logic [YW-1:0]              loc_src_y,
    input  logic [NUM_PORTS*XW-1:0]    in_dst_x,
    input  logic [NUM_PORTS*YW-1:0]    in_dst_y,
    input  logic [NUM_PORTS-1:0]       in_ord,
    output logic [NUM_PORTS*DIR_W-1:0] out_dir,
    output logic [NUM_PORTS-1:0]       out_ord
);

    logic    inject;
    ord_st_e cur_ord;
    logic [NUM_PORTS-1:0] eff_ord;

    assign inject = loc_vld && (loc_src_x == here_x) && (loc_src_y == here_y);

    rc_order_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .inject    (inject),
        .cur_state (cur_ord)
    );

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
        dir_e dir_k;

        if (k == PORT_LOCAL) begin : g_loc
            always_comb eff_ord[k] = inject ? logic'(cur_ord) : in_ord[k];
        end else begin : g_net
            always_comb eff_ord[k] = in_ord[k];
        end

        rc_dir_calc #(.XW(XW), .YW(YW)) u_calc (
            .cur_x   (here_x),
            .cur_y   (here_y),
            .dst_x   (in_dst_x[k*XW +: XW]),
            .dst_y   (in_dst_y[k*YW +: YW]),
            .y_first (eff_ord[k]),
            .dir     (dir_k)
        );

        assign out_dir[k*DIR_W +: DIR_W] = dir_k;
    end

    assign out_ord = eff_ord;

endmodule

// File: rtl/rc_lb_route_chk.sv
module rc_lb_route_chk
    import rc_pkg::*;
#(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [XW-1:0]              here_x,
    input logic [YW-1:0]              here_y,
    input logic                       inject,
    input ord_st_e                    cur_ord,
    input logic [NUM_PORTS*XW-1:0]    in_dst_x,
    input logic [NUM_PORTS*YW-1:0]    in_dst_y,
    input logic [NUM_PORTS*DIR_W-1:0] out_dir,
    input logic [NUM_PORTS-1:0]       out_ord
);

    p_reset_xfirst_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cur_ord == ST_XFIRST);

    p_toggle_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inject |=> cur_ord != $past(cur_ord));

    p_toggle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !inject |=> $stable(cur_ord));

    p_inject_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inject |-> out_ord[PORT_LOCAL] == logic'(cur_ord));

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_chk
        p_eject_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_dst_x[k*XW +: XW] == here_x && in_dst_y[k*YW +: YW] == here_y)
            |-> out_dir[k*DIR_W +: DIR_W] == DIR_LOCAL);

        p_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
            out_dir[k*DIR_W +: DIR_W] <= DIR_SOUTH);
    end

endmodule

bind rc_lb_route rc_lb_route_chk #(.XW(XW), .YW(YW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .here_x   (here_x),
    .here_y   (here_y),
    .inject   (inject),
    .cur_ord  (cur_ord),
    .in_dst_x (in_dst_x),
    .in_dst_y (in_dst_y),
    .out_dir  (out_dir),
    .out_ord  (out_ord)
);

// File: tb/rc_lb_route_test.sv
module rc_lb_route_test;

    localparam int CLK_PERIOD = 10;
    localparam int XW = 3;
    localparam int YW = 3;
    localparam int NP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [XW-1:0] here_x = '0;
    logic [YW-1:0] here_y = '0;
    logic          loc_vld = 1'b0;
    logic [XW-1:0] loc_src_x = '0;
    logic [YW-1:0] loc_src_y = '0;
    logic [NP*XW-1:0] in_dst_x = '0;
    logic [NP*YW-1:0] in_dst_y = '0;
    logic [NP-1:0]    in_ord = '0;
    logic [NP*3-1:0]  out_dir;
    logic [NP-1:0]    out_ord;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    bit  mtgl = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc_lb_route #(.XW(XW), .YW(YW)) uut (
        .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
        .loc_vld(loc_vld), .loc_src_x(loc_src_x), .loc_src_y(loc_src_y),
        .in_dst_x(in_dst_x), .in_dst_y(in_dst_y), .in_ord(in_ord),
        .out_dir(out_dir), .out_ord(out_ord)
    );

    function automatic logic [2:0] exp_dir(input logic [XW-1:0] cx, input logic [YW-1:0] cy,
                                           input logic [XW-1:0] dx, input logic [YW-1:0] dy,
                                           input logic yf);
        logic [2:0] xm, ym;
        xm = (cx < dx) ? 3'd1 : 3'd2;
        ym = (cy < dy) ? 3'd3 : 3'd4;
        if (cx == dx && cy == dy) return 3'd0;
        if (!yf) return (cx != dx) ? xm : ym;
        return (cy != dy) ? ym : xm;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_port(input int k, input int dx, input int dy, input bit o);
        in_dst_x[k*XW +: XW] = XW'(dx);
        in_dst_y[k*YW +: YW] = YW'(dy);
        in_ord[k] = o;
    endtask

    // Drive at negedge, check all ports, then advance one clock and the model.
    task automatic step_check();
        bit inj, eo;
        logic [XW-1:0] dx;
        logic [YW-1:0] dy;
        string tag;
        inj = loc_vld && loc_src_x == here_x && loc_src_y == here_y;
        #1;
        for (int k = 0; k < NP; k++) begin
            dx = in_dst_x[k*XW +: XW];
            dy = in_dst_y[k*YW +: YW];
            eo = (k == 0 && inj) ? mtgl : in_ord[k];
            if (dx == here_x && dy == here_y) tag = "R4";
            else if (k == 0 && inj) tag = "R3";
            else if (eo) tag = "R7";
            else tag = "R6";
            check({tag, " dir"}, int'(out_dir[k*3 +: 3]), int'(exp_dir(here_x, here_y, dx, dy, eo)));
            check((k == 0 && inj) ? "R3 ord" : "R9 ord", int'(out_ord[k]), int'(eo));
        end
        @(posedge clk);
        if (inj) mtgl = ~mtgl;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mtgl = 0;
        here_x = 3'd2; here_y = 3'd3;
        for (int k = 0; k < NP; k++) set_port(k, 2, 3, 0);

        // R1: first injection after reset is X-first, heads east
        loc_vld = 1; loc_src_x = 3'd2; loc_src_y = 3'd3;
        set_port(0, 5, 6, 1);
        #1;
        check("R1 ord", int'(out_ord[0]), 0);
        check("R1 dir", int'(out_dir[2:0]), 1);
        step_check();
        // R2/R7: second injection Y-first, heads north
        #1;
        check("R2 ord", int'(out_ord[0]), 1);
        check("R7 dir", int'(out_dir[2:0]), 3);
        step_check();
        // R2: invalid local slot leaves state
        loc_vld = 0; step_check();
        // R9: local flit from elsewhere does not flip, uses its own bit
        loc_vld = 1; loc_src_x = 3'd0; set_port(0, 2, 0, 1);
        #1;
        check("R9 dir", int'(out_dir[2:0]), 4);
        step_check();
        // R8: X-first chosen but X already aligned -> north, bit 0, then flip
        loc_src_x = 3'd2; set_port(0, 2, 6, 1);
        #1;
        check("R8 ord", int'(out_ord[0]), 0);
        check("R8 dir", int'(out_dir[2:0]), 3);
        step_check();
        // R8: Y-first chosen but Y aligned -> west
        set_port(0, 0, 3, 0);
        #1;
        check("R8 ord", int'(out_ord[0]), 1);
        check("R8 dir", int'(out_dir[2:0]), 2);
        step_check();
        // R4 on network port, R5 south/west on others
        loc_vld = 0;
        set_port(1, 2, 3, 1); set_port(2, 0, 0, 0); set_port(3, 0, 0, 1); set_port(4, 7, 7, 1);
        #1;
        check("R4 east eject", int'(out_dir[5:3]), 0);
        check("R5 west", int'(out_dir[8:6]), 2);
        check("R5 south", int'(out_dir[11:9]), 4);
        check("R5 north", int'(out_dir[14:12]), 3);
        step_check();

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            if (n % 50 == 0) begin
                here_x = XW'($urandom_range(0, 7));
                here_y = YW'($urandom_range(0, 7));
            end
            loc_vld = ($urandom_range(0, 9) < 8);
            if ($urandom_range(0, 9) < 7) begin
                loc_src_x = here_x; loc_src_y = here_y;
            end else begin
                loc_src_x = XW'($urandom_range(0, 7));
                loc_src_y = YW'($urandom_range(0, 7));
            end
            for (int k = 0; k < NP; k++) begin
                int dx, dy;
                dx = ($urandom_range(0, 3) == 0) ? int'(here_x) : $urandom_range(0, 7);
                dy = ($urandom_range(0, 3) == 0) ? int'(here_y) : $urandom_range(0, 7);
                set_port(k, dx, dy, 1'($urandom_range(0, 1)));
            end
            step_check();
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule